// File: doc/BRIEF.md
# Scan Vector Shift Transactor

This block sits between a host message channel and a scan-chain design under test. The host delivers one complete test vector per inbound message. The transactor then runs the chain on its own: it holds scan enable high and presents the vector on scan-in one bit per advanced clock, least significant bit first. It then drops scan enable for a single capture cycle. After capture it offers the bits that came back on scan-out as one outbound message and asks for the next vector in the same cycle.

A single shift register serves both directions. Vector bits leave at its low end and response bits enter at its high end, so the response of the previous capture is collected while the next vector goes in. The design under test advances only while the clock-advance output is high, and that output is high only in shift and capture cycles. The chain is therefore frozen while the transactor waits on the host. Directly after reset the chain holds zeros, so the first response is zero. Each later response is the capture result of the vector before it.

Top module: `scan_vec_xactor`

## Requirements
- R1: While reset is high, and in the first cycle after reset falls, scan_en, test_mode, clk_adv and out_valid are 0. Reset is synchronous and active high. One cycle after reset is released, in_ready is 1.
- R2: An inbound vector is taken in the cycle where in_valid and in_ready are both 1. On the first vector after reset, test_mode and scan_en rise from 0 to 1 in the same cycle, and clk_adv is 1 in that cycle too.
- R3: Each vector is shifted for exactly CHAIN_LEN (default 21) consecutive cycles with clk_adv=1 and scan_en=1. In shift cycle i (counting from 0), scan_in carries vector bit i, so the least significant bit goes first.
- R4: The cycle directly after the last shift cycle is one capture cycle with clk_adv=1 and scan_en=0. From the next cycle on, scan_en is 1 again.
- R5: scan_out is sampled in every shift cycle. Bit i of the response is the value of scan_out in shift cycle i. For a chain whose input is at the far end and whose output bit is chain bit 0, the response therefore equals the chain contents before the shift.
- R6: The first response after reset is all zeros, which is the reset state of the chain.
- R7: In the cycle after capture, out_valid and in_ready are both 1. out_data does not change while out_valid is 1 and out_ready is 0.
- R8: Shifting of the next vector begins only after both the new vector and the response have been taken, in either order or in the same cycle. clk_adv is 0 in every cycle where in_ready or out_valid is 1.
- R9: Once test_mode is 1, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running transactor clock |
| rst | input | 1 | Synchronous active-high reset of the whole FSM |
| in_valid | input | 1 | Host offers an inbound vector |
| in_ready | output | 1 | Transactor accepts an inbound vector |
| in_data | input | CHAIN_LEN | Test vector; bit 0 is shifted first |
| out_valid | output | 1 | Response message offered |
| out_ready | input | 1 | Host accepts the response |
| out_data | output | CHAIN_LEN | Response; bit 0 is the first bit seen on scan_out |
| scan_in | output | 1 | Serial data to the chain input |
| scan_out | input | 1 | Serial data from the chain output |
| scan_en | output | 1 | 1 selects shift, 0 selects capture |
| test_mode | output | 1 | Chain placed in test mode |
| clk_adv | output | 1 | Request that the design clock advance this cycle |

## Verification
The assertions check on every cycle the following rules: the clock is frozen during any message wait, the shift run before each capture has full length, a capture is followed directly by the paired send-and-fetch, a stalled response holds steady, test mode stays set, and nothing advances before test mode. Some behaviour only the bench scenarios can show. These are the bit order on scan_in, the response contents from a modelled chain with a nontrivial capture function, the zero first response, and the three orders in which the two handshakes can finish.

// File: rtl/scan_xact_pkg.sv
package scan_xact_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_MSG  = 3'd1,
    ST_SHIFT     = 3'd2,
    ST_CAPTURE   = 3'd3,
    ST_SEND_RESP = 3'd4,
    ST_WAIT_ACK  = 3'd5
  } xact_state_t;
endpackage

// File: rtl/scan_bit_counter.sv
module scan_bit_counter #(
  parameter int LIMIT = 21,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam logic [W-1:0] LAST_IDX = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int N = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] ld_data,
  input  logic         shift_en,
  input  logic         ser_in,
  input  logic         latch,
  output logic         ser_out,
  output logic [N-1:0] resp
);
  logic [N-1:0] sreg;

  // vector bits leave at bit 0, returning chain bits enter at the top
  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (load)     sreg <= ld_data;
    else if (shift_en) sreg <= {ser_in, sreg[N-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)        resp <= '0;
    else if (latch) resp <= sreg;
  end

  assign ser_out = sreg[0];
endmodule

// File: rtl/scan_xact_fsm.sv
module scan_xact_fsm
  import scan_xact_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic last,
  output logic in_ready,
  output logic out_valid,
  output logic scan_en,
  output logic test_mode,
  output logic clk_adv,
  output logic load,
  output logic shift_en,
  output logic latch_resp
);
  xact_state_t state, nxt;
  logic out_acc;
  logic tm_nxt;

  assign load       = in_valid && in_ready;
  assign out_acc    = out_valid && out_ready;
  assign shift_en   = (state == ST_SHIFT);
  assign latch_resp = (state == ST_CAPTURE);
  assign tm_nxt     = test_mode || load;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:      nxt = ST_WAIT_MSG;
      ST_WAIT_MSG:  if (load) nxt = ST_SHIFT;
      ST_SHIFT:     if (last) nxt = ST_CAPTURE;
      ST_CAPTURE:   nxt = ST_SEND_RESP;
      ST_SEND_RESP: begin
        if (load && out_acc) nxt = ST_SHIFT;
        else if (out_acc)    nxt = ST_WAIT_MSG;
        else if (load)       nxt = ST_WAIT_ACK;
      end
      ST_WAIT_ACK:  if (out_acc) nxt = ST_SHIFT;
      default:      nxt = ST_IDLE;
    endcase
  end

  // outputs registered from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      clk_adv   <= 1'b0;
      scan_en   <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      state     <= nxt;
      in_ready  <= (nxt == ST_WAIT_MSG) || (nxt == ST_SEND_RESP);
      out_valid <= (nxt == ST_SEND_RESP) || (nxt == ST_WAIT_ACK);
      clk_adv   <= (nxt == ST_SHIFT) || (nxt == ST_CAPTURE);
      scan_en   <= tm_nxt && (nxt != ST_CAPTURE);
      test_mode <= tm_nxt;
    end
  end
endmodule

// File: rtl/scan_vec_xactor.sv
module scan_vec_xactor #(
  parameter int CHAIN_LEN = 21,
  parameter int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [CHAIN_LEN-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CHAIN_LEN-1:0] out_data,
  output logic                 scan_in,
  input  logic                 scan_out,
  output logic                 scan_en,
  output logic                 test_mode,
  output logic                 clk_adv
);
  logic load, shift_en, latch_resp, last;

  scan_xact_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .last       (last),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .scan_en    (scan_en),
    .test_mode  (test_mode),
    .clk_adv    (clk_adv),
    .load       (load),
    .shift_en   (shift_en),
    .latch_resp (latch_resp)
  );

  scan_bit_counter #(.LIMIT(CHAIN_LEN), .W(CNT_W)) i_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (load),
    .inc  (shift_en),
    .last (last)
  );

  scan_shift_reg #(.N(CHAIN_LEN)) i_sreg (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ld_data  (in_data),
    .shift_en (shift_en),
    .ser_in   (scan_out),
    .latch    (latch_resp),
    .ser_out  (scan_in),
    .resp     (out_data)
  );
endmodule

// File: rtl/scan_xact_chk.sv
module scan_xact_chk #(
  parameter int CHAIN_LEN = 21,
  parameter int CNT_W     = $clog2(CHAIN_LEN + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [CHAIN_LEN-1:0] out_data,
  input logic                 scan_en,
  input logic                 test_mode,
  input logic                 clk_adv
);
  localparam logic [CNT_W:0] RUN_FULL = (CNT_W+1)'(CHAIN_LEN);

  logic [CNT_W:0] run;

  always_ff @(posedge clk) begin
    if (rst)                      run <= '0;
    else if (clk_adv && scan_en)  run <= run + 1'b1;
    else if (clk_adv && !scan_en) run <= '0;
  end

  // R8: frozen design clock during any message wait
  a_r8_no_adv_while_wait: assert property (@(posedge clk) disable iff (rst)
    (in_ready || out_valid) |-> !clk_adv);

  // R3: full-length shift run before capture, never longer
  a_r3_shift_len: assert property (@(posedge clk) disable iff (rst)
    (clk_adv && !scan_en) |-> (run == RUN_FULL));
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_FULL);

  // R4, R7: capture followed by simultaneous send and fetch
  a_r4_capture_then_send: assert property (@(posedge clk) disable iff (rst)
    (clk_adv && !scan_en) |=> (out_valid && in_ready && scan_en));

  // R7: stalled response held
  a_r7_out_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: test mode and scan enable rise together
  a_r2_tm_with_se: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode) |-> (scan_en && clk_adv));

  // R9: test mode sticky
  a_r9_tm_sticky: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> test_mode);

  // R1: nothing moves before test mode
  a_r1_quiet_before_tm: assert property (@(posedge clk) disable iff (rst)
    !test_mode |-> (!scan_en && !clk_adv && !out_valid));
endmodule

bind scan_vec_xactor scan_xact_chk #(.CHAIN_LEN(CHAIN_LEN), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .scan_en   (scan_en),
  .test_mode (test_mode),
  .clk_adv   (clk_adv)
);

// File: tb/test_scan_vec_xactor.sv
module test_scan_vec_xactor;
  localparam int N = 21;
  localparam logic [N-1:0] MIX = 21'h0B5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, scan_in, scan_en, test_mode, clk_adv, scan_out;
  logic [N-1:0] out_data;

  always #10 clk = ~clk; // 50 MHz

  scan_vec_xactor #(.CHAIN_LEN(N)) i_scan_vec_xactor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .scan_in(scan_in), .scan_out(scan_out),
    .scan_en(scan_en), .test_mode(test_mode), .clk_adv(clk_adv)
  );

  function automatic logic [N-1:0] capf(input logic [N-1:0] x);
    return {x[N-2:0], x[N-1]} ^ MIX;
  endfunction

  // modelled chain: input at far end, output is bit 0
  logic [N-1:0] chain;
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else if (clk_adv) begin
      if (scan_en) chain <= {scan_in, chain[N-1:1]};
      else         chain <= capf(chain);
    end
  end
  assign scan_out = chain[0];

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_q[$];
  logic [N-1:0] vin_q[$];
  logic [N-1:0] prev_vec = '0;
  bit first_vec = 1'b1;
  int out_stall = 0;
  int resp_idx = 0;

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_vec(input logic [N-1:0] v, input int pre_delay, input int stall);
    repeat (pre_delay) @(negedge clk);
    out_stall = stall;
    exp_q.push_back(first_vec ? '0 : capf(prev_vec));
    vin_q.push_back(v);
    prev_vec = v;
    first_vec = 1'b0;
    in_valid = 1'b1;
    in_data = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  logic [N-1:0] acc = '0;
  int shift_run = 0, caps = 0;
  bit prev_cap = 1'b0, prev_ov = 1'b0, prev_tm = 1'b0, tm_seen = 1'b0;
  int r8_bad = 0, r9_bad = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_stall > 0) begin out_ready = 1'b0; out_stall--; end
      else out_ready = 1'b1;

      if (clk_adv && (in_ready || out_valid)) r8_bad++;
      if (tm_seen && !test_mode) r9_bad++;
      if (test_mode && !prev_tm)
        check(scan_en && clk_adv, "R2 tm/se/adv rise", {18'd0, test_mode, scan_en, clk_adv}, 21'd7);
      if (test_mode) tm_seen = 1'b1;
      if (prev_cap)
        check(scan_en == 1'b1, "R4 scan_en reasserted", {20'd0, scan_en}, 21'd1);

      if (clk_adv && scan_en) begin
        acc = {scan_in, acc[N-1:1]};
        shift_run++;
      end
      if (clk_adv && !scan_en) begin
        logic [N-1:0] vexp;
        vexp = (vin_q.size() > 0) ? vin_q.pop_front() : '1;
        check(shift_run == N, "R3 shift length", N'(shift_run), N'(N));
        check(acc == vexp, "R3 LSB-first scan_in", acc, vexp);
        shift_run = 0;
        caps++;
      end
      if (out_valid && !prev_ov) begin
        check(in_ready, "R7 send with fetch", {20'd0, in_ready}, 21'd1);
        check(caps == 1, "R4 single capture cycle", N'(caps), 21'd1);
        caps = 0;
      end
      if (out_valid && out_ready) begin
        logic [N-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
        if (resp_idx == 0) check(out_data == e, "R6 first response zero", out_data, e);
        else               check(out_data == e, "R5 response", out_data, e);
        resp_idx++;
      end
      prev_cap = clk_adv && !scan_en;
      prev_ov  = out_valid;
      prev_tm  = test_mode;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({scan_en, test_mode, clk_adv, out_valid, in_ready} == 5'b0, "R1 reset quiet",
          {16'd0, scan_en, test_mode, clk_adv, out_valid, in_ready}, '0);
    rst = 1'b0;
    check({scan_en, test_mode, clk_adv, out_valid} == 4'b0, "R1 first cycle quiet",
          {17'd0, scan_en, test_mode, clk_adv, out_valid}, '0);
    @(negedge clk);
    check(in_ready && !test_mode, "R1 ready after reset", {19'd0, in_ready, test_mode}, 21'd2);

    send_vec(21'h000001, 0, 0);
    send_vec(21'h1FFFFF, 0, 0);   // same-cycle handshakes
    send_vec(21'h155555, 0, 5);   // vector first, response stalled (R8)
    send_vec(21'h0AAAAA, 30, 0);  // response first, vector late (R8)
    send_vec(21'h100000, 0, 3);
    send_vec(21'h012345, 12, 0);
    send_vec(21'h0F0F0F, 0, 0);
    send_vec(21'h000000, 0, 2);   // flush
    while (exp_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);

    check(r8_bad == 0, "R8 clock frozen while waiting", N'(r8_bad), '0);
    check(r9_bad == 0, "R9 test mode sticky", N'(r9_bad), '0);
    check(resp_idx == 8, "R5 response count", N'(resp_idx), 21'd8);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule